// File: doc/BRIEF.md
# Multi-CPU Interrupt Distributor

This block collects interrupt lines from peripherals and from software and presents, to each of up to eight CPU interfaces, the single most urgent interrupt that the CPU may take. For each CPU it outputs a valid flag, the ID of that interrupt and its priority. Software programs the block through a simple 32-bit register bus. The registers set a global forwarding switch, per-source enables, a priority byte per source, a CPU-routing byte per source and a trigger mode per source. Software can also force sources pending or clear them, and can raise software interrupts on a chosen set of CPUs.

IDs 0 to 31 are private to each CPU. Their enable, pending and active state exists once per CPU, and the `bus_cpu` input selects which copy a bus access sees. IDs 0 to 15 have no input line and can be raised only from software. IDs 16 to 31 take one line per CPU. IDs 32 and up are shared, and their routing bytes decide which CPUs see them. Each CPU interface reports, through acknowledge and end-of-interrupt strobes, when it takes an interrupt and when it finishes one. An acknowledged source is active and is not offered again until its end-of-interrupt. With the default output register, a state change shows on the forward outputs one clock later. A read returns its data one clock after the read strobe.

Top module: `irq_distributor`

## Requirements
- R1: After reset, each CPU's forward output is invalid with ID 1023 and priority 0, and the control word reads 0. Whenever a CPU's valid flag is low, its ID output is 1023.
- R2: The enable-set bank is at byte 0x100 and the enable-clear bank at 0x180. ID i sits in word i/32, bit i%32. Writing a 1 sets or clears that enable, and writing a 0 changes nothing. Both banks read back the current enables.
- R3: Bit 0 of the control word at 0x000 switches forwarding. While it is 0, no CPU receives a valid interrupt.
- R4: The priority bytes start at 0x400, with ID i in byte i%4 (bits 8*(i%4)+7 down to 8*(i%4)) of word i/4. Among the interrupts a CPU may take, the lowest priority value wins, and on equal values the lowest ID wins.
- R5: The routing bytes start at 0x800, laid out like the priority bytes. For a shared ID, bit c of its byte lets CPU c receive it.
- R6: A source set to level mode is pending while its line is high and it is not active. The pending-set bank at 0x200 and the pending-clear bank at 0x280 read back the current pending state.
- R7: An acknowledge from a CPU moves the given ID from pending to active. The active bank at 0x300 shows it, and the ID is no longer forwarded. An end-of-interrupt clears the active bit.
- R8: The trigger bank at 0xC00 holds 2 bits per source, 16 sources per word, with ID i at bits 2*(i%16)+1 down to 2*(i%16). Value 0 selects level mode. When the upper bit is 1, a rising edge on the line latches the source pending until it is acknowledged or cleared.
- R9: Writing 1 to a bit of the pending-set bank latches that source pending, and writing 1 to the matching pending-clear bit removes the latch.
- R10: Enable, pending and active for IDs 0 to 31 are separate for each CPU and selected by `bus_cpu`. These IDs reach only their own CPU, and their routing bytes read as the accessing CPU's bit.
- R11: A write to 0xF00 latches ID wdata[3:0] pending in the private bank of each CPU c whose bit wdata[16+c] is 1.
- R12: The type word at 0x004 reads (NUM_SRC/32-1) in bits 4:0 and (NUM_CPUS-1) in bits 7:5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cpu | input | CPU_W | Index of the CPU making the bus access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data is valid on the next clock |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| shared_irq_i | input | NUM_SRC-32 | Lines of shared IDs 32 and up |
| priv_irq_i | input | NUM_CPUS*16 | Lines of private IDs 16 to 31, 16 per CPU |
| ack_i | input | NUM_CPUS | Acknowledge strobe, one per CPU |
| ack_id_i | input | NUM_CPUS*10 | Acknowledged ID, one per CPU |
| eoi_i | input | NUM_CPUS | End-of-interrupt strobe, one per CPU |
| eoi_id_i | input | NUM_CPUS*10 | Finished ID, one per CPU |
| fwd_valid_o | output | NUM_CPUS | A forwardable interrupt exists for the CPU |
| fwd_id_o | output | NUM_CPUS*10 | ID of the winning interrupt per CPU |
| fwd_prio_o | output | NUM_CPUS*8 | Priority of the winning interrupt per CPU |

## Verification
The bench builds the block with two CPUs, 64 sources and the registered output. With two CPUs, a private ID can be enabled for one CPU and stay disabled for the other, a shared ID can be routed to one CPU and then to both, and a software interrupt can be aimed at just one of them. With 64 sources, there is a second enable and pending word holding the shared IDs. This lets the bench check word and bit placement beyond word 0, and the per-source priority and routing bytes of shared IDs.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
   localparam int ID_W     = 10;
   localparam int PRIO_W   = 8;
   localparam int SPUR_ID  = 1023;
   localparam int PRIV_N   = 32;
   localparam int PRIV_LN  = 16;
   // word addresses (byte address / 4)
   localparam int W_CTRL = 'h000;
   localparam int W_TYPE = 'h001;
   localparam int W_ENS  = 'h040;
   localparam int W_ENC  = 'h060;
   localparam int W_PNS  = 'h080;
   localparam int W_PNC  = 'h0A0;
   localparam int W_ACT  = 'h0C0;
   localparam int W_PRI  = 'h100;
   localparam int W_TGT  = 'h200;
   localparam int W_CFG  = 'h300;
   localparam int W_SGI  = 'h3C0;
endpackage

// File: rtl/irqd_regs.sv
module irqd_regs
   import irqd_pkg::*;
#(
   parameter int NUM_CPUS = 2,
   parameter int NUM_SRC  = 64,
   localparam int CPU_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
   localparam int SH      = NUM_SRC - PRIV_N
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [CPU_W-1:0]              bus_cpu,
   input  logic                          bus_wr,
   input  logic                          bus_rd,
   input  logic [11:0]                   bus_addr,
   input  logic [31:0]                   bus_wdata,
   output logic [31:0]                   bus_rdata,
   input  logic [SH-1:0]                 shared_irq_i,
   input  logic [NUM_CPUS*PRIV_LN-1:0]   priv_irq_i,
   input  logic [NUM_CPUS-1:0]           ack_i,
   input  logic [NUM_CPUS*ID_W-1:0]      ack_id_i,
   input  logic [NUM_CPUS-1:0]           eoi_i,
   input  logic [NUM_CPUS*ID_W-1:0]      eoi_id_i,
   output logic                          glob_en_o,
   output logic [SH-1:0]                 sh_act_o,
   output logic [NUM_CPUS*NUM_SRC-1:0]   cand_o,
   output logic [NUM_SRC*PRIO_W-1:0]     prio_o
);
   logic                glob_en;
   logic [PRIV_N-1:0]   p_en   [NUM_CPUS];
   logic [PRIV_N-1:0]   p_lat  [NUM_CPUS];
   logic [PRIV_N-1:0]   p_act  [NUM_CPUS];
   logic [PRIV_LN-1:0]  p_line_q [NUM_CPUS];
   logic [SH-1:0]       s_en, s_lat, s_act, s_line_q;
   logic [PRIO_W-1:0]   prio [NUM_SRC];
   logic [7:0]          tgt  [SH];
   logic [1:0]          trig [NUM_SRC];

   logic [NUM_SRC-1:0]  en_v   [NUM_CPUS];
   logic [NUM_SRC-1:0]  act_v  [NUM_CPUS];
   logic [NUM_SRC-1:0]  lat_v  [NUM_CPUS];
   logic [NUM_SRC-1:0]  line_v [NUM_CPUS];
   logic [NUM_SRC-1:0]  pend_v [NUM_CPUS];
   logic [NUM_SRC-1:0]  lvl;
   logic [9:0]          waddr;
   logic [31:0]         rmux;

   assign waddr     = bus_addr[11:2];
   assign glob_en_o = glob_en;
   assign sh_act_o  = s_act;

   // per-CPU views of the full ID space
   always_comb begin
      for (int i = 0; i < NUM_SRC; i++) lvl[i] = ~trig[i][1];
      for (int c = 0; c < NUM_CPUS; c++) begin
         en_v[c]   = {s_en,  p_en[c]};
         act_v[c]  = {s_act, p_act[c]};
         lat_v[c]  = {s_lat, p_lat[c]};
         line_v[c] = {shared_irq_i, priv_irq_i[c*PRIV_LN +: PRIV_LN], {PRIV_LN{1'b0}}};
         pend_v[c] = lat_v[c] | (lvl & line_v[c] & ~act_v[c]);
      end
   end

   // forwardable sources per CPU
   always_comb begin
      for (int c = 0; c < NUM_CPUS; c++) begin
         for (int i = 0; i < NUM_SRC; i++) begin
            logic route;
            if (i < PRIV_N) route = 1'b1;
            else            route = tgt[i-PRIV_N][c];
            cand_o[c*NUM_SRC+i] = glob_en & en_v[c][i] & pend_v[c][i] & ~act_v[c][i] & route;
         end
      end
      for (int i = 0; i < NUM_SRC; i++) prio_o[i*PRIO_W +: PRIO_W] = prio[i];
   end

   // read mux
   always_comb begin
      rmux = '0;
      if (waddr == 10'(W_CTRL)) rmux[0] = glob_en;
      if (waddr == 10'(W_TYPE)) rmux = {24'd0, 3'(NUM_CPUS-1), 5'(NUM_SRC/32-1)};
      for (int i = 0; i < NUM_SRC; i++) begin
         if (waddr == 10'(W_ENS + i/32) || waddr == 10'(W_ENC + i/32))
            rmux[i%32] = en_v[bus_cpu][i];
         if (waddr == 10'(W_PNS + i/32) || waddr == 10'(W_PNC + i/32))
            rmux[i%32] = pend_v[bus_cpu][i];
         if (waddr == 10'(W_ACT + i/32))
            rmux[i%32] = act_v[bus_cpu][i];
         if (waddr == 10'(W_PRI + i/4))
            rmux[8*(i%4) +: 8] = prio[i];
         if (waddr == 10'(W_TGT + i/4)) begin
            if (i < PRIV_N) rmux[8*(i%4) +: 8] = 8'(1) << bus_cpu;
            else            rmux[8*(i%4) +: 8] = tgt[i-PRIV_N];
         end
         if (waddr == 10'(W_CFG + i/16))
            rmux[2*(i%16) +: 2] = trig[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) bus_rdata <= '0;
      else        bus_rdata <= bus_rd ? rmux : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         glob_en  <= 1'b0;
         s_en     <= '0;
         s_lat    <= '0;
         s_act    <= '0;
         s_line_q <= '0;
         for (int c = 0; c < NUM_CPUS; c++) begin
            p_en[c]     <= '0;
            p_lat[c]    <= '0;
            p_act[c]    <= '0;
            p_line_q[c] <= '0;
         end
         for (int i = 0; i < NUM_SRC; i++) begin
            prio[i] <= '0;
            trig[i] <= '0;
         end
         for (int j = 0; j < SH; j++) tgt[j] <= '0;
      end else begin
         // edge capture
         s_line_q <= shared_irq_i;
         for (int j = 0; j < SH; j++)
            if (trig[PRIV_N+j][1] && shared_irq_i[j] && !s_line_q[j]) s_lat[j] <= 1'b1;
         for (int c = 0; c < NUM_CPUS; c++) begin
            p_line_q[c] <= priv_irq_i[c*PRIV_LN +: PRIV_LN];
            for (int k = 0; k < PRIV_LN; k++)
               if (trig[PRIV_LN+k][1] && priv_irq_i[c*PRIV_LN+k] && !p_line_q[c][k])
                  p_lat[c][PRIV_LN+k] <= 1'b1;
         end
         // register writes
         if (bus_wr) begin
            if (waddr == 10'(W_CTRL)) glob_en <= bus_wdata[0];
            for (int i = 0; i < NUM_SRC; i++) begin
               if (i < PRIV_N) begin
                  for (int c = 0; c < NUM_CPUS; c++) begin
                     if (CPU_W'(c) == bus_cpu && bus_wdata[i%32]) begin
                        if (waddr == 10'(W_ENS)) p_en[c][i]  <= 1'b1;
                        if (waddr == 10'(W_ENC)) p_en[c][i]  <= 1'b0;
                        if (waddr == 10'(W_PNS)) p_lat[c][i] <= 1'b1;
                        if (waddr == 10'(W_PNC)) p_lat[c][i] <= 1'b0;
                     end
                  end
               end else begin
                  if (bus_wdata[i%32]) begin
                     if (waddr == 10'(W_ENS + i/32)) s_en[i-PRIV_N]  <= 1'b1;
                     if (waddr == 10'(W_ENC + i/32)) s_en[i-PRIV_N]  <= 1'b0;
                     if (waddr == 10'(W_PNS + i/32)) s_lat[i-PRIV_N] <= 1'b1;
                     if (waddr == 10'(W_PNC + i/32)) s_lat[i-PRIV_N] <= 1'b0;
                  end
                  if (waddr == 10'(W_TGT + i/4)) tgt[i-PRIV_N] <= bus_wdata[8*(i%4) +: 8];
               end
               if (waddr == 10'(W_PRI + i/4))  prio[i] <= bus_wdata[8*(i%4) +: 8];
               if (waddr == 10'(W_CFG + i/16)) trig[i] <= bus_wdata[2*(i%16) +: 2];
            end
            if (waddr == 10'(W_SGI))
               for (int c = 0; c < NUM_CPUS; c++)
                  if (bus_wdata[16+c]) p_lat[c][bus_wdata[3:0]] <= 1'b1;
         end
         // acknowledge: pending to active
         for (int c = 0; c < NUM_CPUS; c++) begin
            if (ack_i[c]) begin
               for (int i = 0; i < NUM_SRC; i++) begin
                  if (ack_id_i[c*ID_W +: ID_W] == ID_W'(i)) begin
                     if (i < PRIV_N) begin
                        p_lat[c][i] <= 1'b0;
                        p_act[c][i] <= 1'b1;
                     end else begin
                        s_lat[i-PRIV_N] <= 1'b0;
                        s_act[i-PRIV_N] <= 1'b1;
                     end
                  end
               end
            end
         end
         // end of interrupt: retire active
         for (int c = 0; c < NUM_CPUS; c++) begin
            if (eoi_i[c]) begin
               for (int i = 0; i < NUM_SRC; i++) begin
                  if (eoi_id_i[c*ID_W +: ID_W] == ID_W'(i)) begin
                     if (i < PRIV_N) p_act[c][i]      <= 1'b0;
                     else            s_act[i-PRIV_N]  <= 1'b0;
                  end
               end
            end
         end
      end
   end
endmodule

// File: rtl/irqd_arbiter.sv
module irqd_arbiter
   import irqd_pkg::*;
#(
   parameter int NUM_SRC = 64,
   parameter bit REG_OUT = 1'b1
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_SRC-1:0]        cand_i,
   input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
   output logic                      valid_o,
   output logic [ID_W-1:0]           id_o,
   output logic [PRIO_W-1:0]         prio_o
);
   logic              found;
   logic [ID_W-1:0]   best_id;
   logic [PRIO_W-1:0] best_p;

   // linear scan: strict less-than keeps the lowest ID on ties
   always_comb begin
      found   = 1'b0;
      best_id = ID_W'(SPUR_ID);
      best_p  = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (cand_i[i] && (!found || prio_i[i*PRIO_W +: PRIO_W] < best_p)) begin
            found   = 1'b1;
            best_id = ID_W'(i);
            best_p  = prio_i[i*PRIO_W +: PRIO_W];
         end
      end
   end

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               valid_o <= 1'b0;
               id_o    <= ID_W'(SPUR_ID);
               prio_o  <= '0;
            end else begin
               valid_o <= found;
               id_o    <= best_id;
               prio_o  <= best_p;
            end
         end
      end else begin : g_comb
         assign valid_o = found;
         assign id_o    = best_id;
         assign prio_o  = best_p;
      end
   endgenerate
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
   import irqd_pkg::*;
#(
   parameter int NUM_CPUS = 2,
   parameter int NUM_SRC  = 64,
   parameter bit REG_OUT  = 1'b1,
   localparam int CPU_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [CPU_W-1:0]              bus_cpu,
   input  logic                          bus_wr,
   input  logic                          bus_rd,
   input  logic [11:0]                   bus_addr,
   input  logic [31:0]                   bus_wdata,
   output logic [31:0]                   bus_rdata,
   input  logic [NUM_SRC-33:0]           shared_irq_i,
   input  logic [NUM_CPUS*16-1:0]        priv_irq_i,
   input  logic [NUM_CPUS-1:0]           ack_i,
   input  logic [NUM_CPUS*10-1:0]        ack_id_i,
   input  logic [NUM_CPUS-1:0]           eoi_i,
   input  logic [NUM_CPUS*10-1:0]        eoi_id_i,
   output logic [NUM_CPUS-1:0]           fwd_valid_o,
   output logic [NUM_CPUS*10-1:0]        fwd_id_o,
   output logic [NUM_CPUS*8-1:0]         fwd_prio_o
);
   localparam int SH = NUM_SRC - PRIV_N;

   if (NUM_SRC % 32 != 0) begin : g_bad_mult
      $error("NUM_SRC must be a multiple of 32");
   end
   if (NUM_SRC < 64 || NUM_SRC > 992) begin : g_bad_range
      $error("NUM_SRC must lie in 64..992");
   end
   if (NUM_CPUS < 1 || NUM_CPUS > 8) begin : g_bad_cpus
      $error("NUM_CPUS must lie in 1..8");
   end

   logic                        glob_en;
   logic [SH-1:0]               sh_act;
   logic [NUM_CPUS*NUM_SRC-1:0] cand;
   logic [NUM_SRC*PRIO_W-1:0]   prio_flat;

   irqd_regs #(.NUM_CPUS(NUM_CPUS), .NUM_SRC(NUM_SRC)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_cpu(bus_cpu), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .shared_irq_i(shared_irq_i), .priv_irq_i(priv_irq_i),
      .ack_i(ack_i), .ack_id_i(ack_id_i), .eoi_i(eoi_i), .eoi_id_i(eoi_id_i),
      .glob_en_o(glob_en), .sh_act_o(sh_act), .cand_o(cand), .prio_o(prio_flat)
   );

   for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
      irqd_arbiter #(.NUM_SRC(NUM_SRC), .REG_OUT(REG_OUT)) u_arb (
         .clk(clk), .rst_n(rst_n),
         .cand_i(cand[c*NUM_SRC +: NUM_SRC]),
         .prio_i(prio_flat),
         .valid_o(fwd_valid_o[c]),
         .id_o(fwd_id_o[c*ID_W +: ID_W]),
         .prio_o(fwd_prio_o[c*PRIO_W +: PRIO_W])
      );
   end
endmodule

// File: rtl/irqd_checker.sv
module irqd_checker #(
   parameter int NUM_CPUS = 2,
   parameter int NUM_SRC  = 64
)(
   input logic                    clk,
   input logic                    rst_n,
   input logic                    glob_en,
   input logic [NUM_SRC-33:0]     sh_act,
   input logic [NUM_CPUS-1:0]     ack_i,
   input logic [NUM_CPUS*10-1:0]  ack_id_i,
   input logic [NUM_CPUS-1:0]     eoi_i,
   input logic [NUM_CPUS*10-1:0]  eoi_id_i,
   input logic [NUM_CPUS-1:0]     fwd_valid_o,
   input logic [NUM_CPUS*10-1:0]  fwd_id_o
);
   AST_GLOBAL_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (!glob_en && $past(!glob_en)) |-> (fwd_valid_o == '0)); // R3

   for (genvar c = 0; c < NUM_CPUS; c++) begin : g_c
      AST_IDLE_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
         !fwd_valid_o[c] |-> (fwd_id_o[c*10 +: 10] == 10'd1023)); // R1

      AST_ID_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
         fwd_valid_o[c] |-> (int'(fwd_id_o[c*10 +: 10]) < NUM_SRC)); // R4

      AST_ACK_ACTIVATES: assert property (@(posedge clk) disable iff (!rst_n)
         (ack_i[c] && eoi_i == '0 && int'(ack_id_i[c*10 +: 10]) >= 32
          && int'(ack_id_i[c*10 +: 10]) < NUM_SRC)
         |=> sh_act[int'($past(ack_id_i[c*10 +: 10])) - 32]); // R7

      AST_EOI_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
         (eoi_i[c] && int'(eoi_id_i[c*10 +: 10]) >= 32
          && int'(eoi_id_i[c*10 +: 10]) < NUM_SRC)
         |=> !sh_act[int'($past(eoi_id_i[c*10 +: 10])) - 32]); // R7
   end
endmodule

bind irq_distributor irqd_checker #(.NUM_CPUS(NUM_CPUS), .NUM_SRC(NUM_SRC)) u_chk (
   .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .sh_act(sh_act),
   .ack_i(ack_i), .ack_id_i(ack_id_i), .eoi_i(eoi_i), .eoi_id_i(eoi_id_i),
   .fwd_valid_o(fwd_valid_o), .fwd_id_o(fwd_id_o)
);

// File: tb/irq_distributor_tb_top.sv
module irq_distributor_tb_top;
   localparam int NC = 2;
   localparam int NS = 64;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [0:0]        bus_cpu = '0;
   logic              bus_wr = 1'b0, bus_rd = 1'b0;
   logic [11:0]       bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic [NS-33:0]    shared_irq = '0;
   logic [NC*16-1:0]  priv_irq = '0;
   logic [NC-1:0]     ack = '0, eoi = '0;
   logic [NC*10-1:0]  ack_id = '0, eoi_id = '0;
   logic [NC-1:0]     fwd_valid;
   logic [NC*10-1:0]  fwd_id;
   logic [NC*8-1:0]   fwd_prio;

   always #2ns clk = ~clk;

   irq_distributor #(.NUM_CPUS(NC), .NUM_SRC(NS), .REG_OUT(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_cpu(bus_cpu), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .shared_irq_i(shared_irq), .priv_irq_i(priv_irq),
      .ack_i(ack), .ack_id_i(ack_id), .eoi_i(eoi), .eoi_id_i(eoi_id),
      .fwd_valid_o(fwd_valid), .fwd_id_o(fwd_id), .fwd_prio_o(fwd_prio)
   );

   typedef struct {
      bit          is_fwd;
      int          cpu;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t q[$];
   event  chk_ev;
   int    checks = 0, fails = 0;
   bit    done = 1'b0;

   // monitor: pops expected items and compares with the design's outputs
   initial forever begin
      @(chk_ev);
      while (q.size() > 0) begin
         item_t it;
         logic [31:0] act;
         it = q.pop_front();
         if (it.is_fwd)
            act = {13'd0, fwd_valid[it.cpu], fwd_id[it.cpu*10 +: 10], fwd_prio[it.cpu*8 +: 8]};
         else
            act = bus_rdata;
         checks++;
         if (act !== it.exp) begin
            fails++;
            $display("FAIL %s cpu%0d actual=%h expected=%h", it.tag, it.cpu, act, it.exp);
         end
      end
   end

   task automatic push(bit f, int cpu, logic [31:0] e, string tag);
      item_t it;
      it.is_fwd = f; it.cpu = cpu; it.exp = e; it.tag = tag;
      q.push_back(it);
      -> chk_ev;
      #1ps;
   endtask

   task automatic wr(int cpu, logic [11:0] a, logic [31:0] d);
      @(negedge clk);
      bus_cpu = 1'(cpu); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(int cpu, logic [11:0] a, logic [31:0] e, string tag);
      @(negedge clk);
      bus_cpu = 1'(cpu); bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      push(1'b0, cpu, e, tag);
   endtask

   task automatic settle();
      repeat (2) @(negedge clk);
   endtask

   task automatic fwd(int cpu, bit v, int id, int p, string tag);
      push(1'b1, cpu, {13'd0, v, 10'(id), 8'(p)}, tag);
   endtask

   task automatic do_ack(int cpu, int id);
      @(negedge clk);
      ack[cpu] = 1'b1; ack_id[cpu*10 +: 10] = 10'(id);
      @(negedge clk);
      ack[cpu] = 1'b0;
      settle();
   endtask

   task automatic do_eoi(int cpu, int id);
      @(negedge clk);
      eoi[cpu] = 1'b1; eoi_id[cpu*10 +: 10] = 10'(id);
      @(negedge clk);
      eoi[cpu] = 1'b0;
      settle();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state, R12 type word
      fwd(0, 0, 1023, 0, "R1");
      fwd(1, 0, 1023, 0, "R1");
      rd(0, 12'h000, 32'h0, "R1");
      rd(0, 12'h004, 32'h21, "R12");
      // R2 enable set / clear
      wr(0, 12'h104, 32'hC);
      rd(0, 12'h104, 32'hC, "R2");
      wr(0, 12'h184, 32'h8);
      rd(0, 12'h104, 32'h4, "R2");
      rd(0, 12'h184, 32'h4, "R2");
      wr(0, 12'h104, 32'h0);
      wr(0, 12'h184, 32'h0);
      rd(1, 12'h104, 32'h4, "R2");
      // priorities and routing of 32..35
      wr(0, 12'h420, 32'h10203040);
      wr(0, 12'h820, 32'h02010101);
      rd(0, 12'h420, 32'h10203040, "R4");
      // R3 source 34 pending but forwarding off
      shared_irq[2] = 1'b1;
      settle();
      fwd(0, 0, 1023, 0, "R3");
      rd(0, 12'h204, 32'h4, "R6");
      wr(0, 12'h000, 32'h1);
      settle();
      fwd(0, 1, 34, 8'h20, "R3");
      fwd(1, 0, 1023, 0, "R5");
      // R4 lower value wins over lower ID, then tie goes to lower ID
      wr(0, 12'h104, 32'h2);
      shared_irq[1] = 1'b1;
      settle();
      fwd(0, 1, 34, 8'h20, "R4");
      wr(0, 12'h420, 32'h10303040);
      settle();
      fwd(0, 1, 33, 8'h30, "R4");
      // R5 routing
      wr(0, 12'h104, 32'h8);
      shared_irq[3] = 1'b1;
      settle();
      fwd(1, 1, 35, 8'h10, "R5");
      fwd(0, 1, 33, 8'h30, "R5");
      wr(0, 12'h820, 32'h03010101);
      settle();
      fwd(0, 1, 35, 8'h10, "R5");
      wr(0, 12'h820, 32'h02010101);
      settle();
      fwd(0, 1, 33, 8'h30, "R5");
      // R6 level follows line
      shared_irq[1] = 1'b0;
      settle();
      fwd(0, 1, 34, 8'h30, "R6");
      rd(0, 12'h204, 32'hC, "R6");
      // R7 acknowledge and end of interrupt
      do_ack(0, 34);
      fwd(0, 0, 1023, 0, "R7");
      rd(0, 12'h304, 32'h4, "R7");
      rd(0, 12'h204, 32'h8, "R7");
      do_eoi(0, 34);
      fwd(0, 1, 34, 8'h30, "R7");
      rd(0, 12'h304, 32'h0, "R7");
      // R8 edge mode on source 36
      wr(0, 12'hC08, 32'h200);
      wr(0, 12'h424, 32'h05);
      wr(0, 12'h824, 32'h01);
      wr(0, 12'h104, 32'h10);
      rd(0, 12'hC08, 32'h200, "R8");
      @(negedge clk); shared_irq[4] = 1'b1;
      @(negedge clk); shared_irq[4] = 1'b0;
      settle();
      fwd(0, 1, 36, 8'h05, "R8");
      rd(0, 12'h204, 32'h1C, "R8");
      do_ack(0, 36);
      rd(0, 12'h204, 32'hC, "R8");
      rd(0, 12'h304, 32'h10, "R8");
      do_eoi(0, 36);
      fwd(0, 1, 34, 8'h30, "R8");
      // R9 pending set / clear on source 37 (line low)
      wr(0, 12'h824, 32'h0101);
      wr(0, 12'h104, 32'h20);
      wr(0, 12'h204, 32'h20);
      settle();
      fwd(0, 1, 37, 8'h00, "R9");
      wr(0, 12'h284, 32'h0);
      settle();
      fwd(0, 1, 37, 8'h00, "R9");
      wr(0, 12'h284, 32'h20);
      settle();
      fwd(0, 1, 34, 8'h30, "R9");
      rd(0, 12'h204, 32'hC, "R9");
      // R10 banked private ID 20
      wr(0, 12'h414, 32'h01);
      wr(0, 12'h100, 32'h0010_0000);
      rd(0, 12'h100, 32'h0010_0000, "R10");
      rd(1, 12'h100, 32'h0, "R10");
      priv_irq[4]  = 1'b1;
      priv_irq[20] = 1'b1;
      settle();
      fwd(0, 1, 20, 8'h01, "R10");
      fwd(1, 1, 35, 8'h10, "R10");
      rd(1, 12'h814, 32'h02020202, "R10");
      rd(0, 12'h814, 32'h01010101, "R10");
      // R11 software interrupt ID 5 to CPU1 only
      wr(1, 12'h100, 32'h20);
      wr(0, 12'hF00, 32'h0002_0005);
      settle();
      fwd(1, 1, 5, 8'h00, "R11");
      fwd(0, 1, 20, 8'h01, "R11");
      rd(1, 12'h200, 32'h0010_0020, "R11");
      rd(0, 12'h200, 32'h0010_0000, "R11");
      // R3 forwarding off again
      wr(0, 12'h000, 32'h0);
      settle();
      fwd(0, 0, 1023, 0, "R3");
      fwd(1, 0, 1023, 0, "R3");
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule